// File: doc/BRIEF.md
# Shifted-Operand ALU with Flags

This block is the data-processing stage of a small 32-bit RISC core. Each operation takes a register value as its first operand. The second operand is either a register value or an immediate, and it goes through a barrel shifter in the same cycle before it reaches the arithmetic and logic unit. The block computes moves, arithmetic, bitwise logic and the three flag-only operations: compare, test and test-equal. It returns a result, a flag that says whether the result should be written to a register, and the current N/Z/C/V flag register. A per-operation set-flags bit controls whether the flag register is updated.

Operations enter through a valid/ready port. Results leave through a single output register with its own valid/ready port. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds all of its values and no new operation is accepted. The flag register is updated at the edge where the operation is accepted, so `out_flags` always shows the flags that result from the operation currently presented.

Top module: `shift_alu`

## Requirements
- R1: When `in_b_imm` is 1, the second operand before shifting is `in_imm`. When it is 0, the second operand is `in_b_reg`.
- R2: The shift type is set by `in_sh_type`: 0 shift left logical, 1 shift right logical, 2 shift right arithmetic, 3 rotate right. The shift distance is `in_sh_amt`, from 0 to 31. The shifter carry-out is the last bit shifted out. A distance of 0 passes the operand through unchanged, and the carry-out is then the current C flag.
- R3: Opcode 0 (move) writes the shifted operand B. Opcode 1 (move-not) writes its bitwise inverse.
- R4: Opcode 2 writes A + B. Opcode 3 writes A - B. Both use modulo 2^32 arithmetic.
- R5: Opcode 4 writes A AND B, opcode 5 writes A OR B, opcode 6 writes A XOR B, and opcode 7 (bit-clear) writes A AND NOT B.
- R6: Opcode 8 (compare, A - B), opcode 9 (test, A AND B) and opcode 10 (test-equal, A XOR B) present their value on `out_result` with `out_wr_en` at 0. Every opcode from 0 to 7 sets `out_wr_en` to 1.
- R7: The flags are packed in `out_flags` as {N,Z,C,V}, with N at bit 3 and V at bit 0. For opcodes 2, 3 and 8 with set-flags, N is the result's top bit and Z is set when the result is zero. C is the unsigned carry-out for add, or the no-borrow condition (A >= B unsigned) for subtract and compare. V is set on signed overflow.
- R8: For opcodes 0, 1, 4 to 7, 9 and 10 with set-flags, N and Z come from the result, C takes the shifter carry-out, and V keeps its previous value.
- R9: When `in_set_flags` is 0, or the opcode is reserved, `out_flags` keeps its previous value.
- R10: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result`, `out_wr_en` and `out_flags` hold steady. Results leave in the order their operations were accepted.
- R11: Opcodes 11 to 15 are reserved. They produce a result of 0 with `out_wr_en` at 0.
- R12: After reset, `out_valid` is 0, `out_flags` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Opcode (see R3 to R6, R11) |
| in_set_flags | input | 1 | Update flag register |
| in_b_imm | input | 1 | Select immediate as operand B |
| in_a | input | 32 | Operand A (register value) |
| in_b_reg | input | 32 | Operand B register value |
| in_imm | input | 32 | Operand B immediate value |
| in_sh_type | input | 2 | Shift type |
| in_sh_amt | input | 5 | Shift distance |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| out_result | output | 32 | Result value |
| out_wr_en | output | 1 | Result should be written to a register |
| out_flags | output | 4 | Flag register {N,Z,C,V} |

## Verification
The hardest case to reach is a shift by zero: its carry-out is the C flag left behind by earlier operations. The stimulus therefore sets C and clears it on purpose with flag-setting subtracts and compares, and then issues logical operations with a distance of 0. A second hard case is an output held under back-pressure while an operation is waiting at the input. The consumer's ready signal is withheld at random for long stretches of the run, so the hold and ordering rules are tested while the input is still offering work.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OPC_MOV = 4'd0;
  localparam logic [3:0] OPC_MVN = 4'd1;
  localparam logic [3:0] OPC_ADD = 4'd2;
  localparam logic [3:0] OPC_SUB = 4'd3;
  localparam logic [3:0] OPC_AND = 4'd4;
  localparam logic [3:0] OPC_ORR = 4'd5;
  localparam logic [3:0] OPC_EOR = 4'd6;
  localparam logic [3:0] OPC_BIC = 4'd7;
  localparam logic [3:0] OPC_CMP = 4'd8;
  localparam logic [3:0] OPC_TST = 4'd9;
  localparam logic [3:0] OPC_TEQ = 4'd10;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/operand_shifter.sv
module operand_shifter import alu_pkg::*; #(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  shift_kind_e   kind,
  input  logic [SW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  logic [SW-1:0] up_idx;
  logic [SW-1:0] dn_idx;

  always_comb begin
    up_idx = SW'(W) - amt;
    dn_idx = amt - SW'(1);
    if (amt == '0) begin
      dout = din;
      cout = cin;
    end else begin
      unique case (kind)
        SH_LSL: begin
          dout = din << amt;
          cout = din[up_idx];
        end
        SH_LSR: begin
          dout = din >> amt;
          cout = din[dn_idx];
        end
        SH_ASR: begin
          dout = W'($signed(din) >>> amt);
          cout = din[dn_idx];
        end
        default: begin
          dout = (din >> amt) | (din << up_idx);
          cout = din[dn_idx];
        end
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core import alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sh_c,
  input  logic [3:0]   op,
  input  flags_t       flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         known,
  output flags_t       flags_out
);
  logic [W:0] sum_w;
  logic [W:0] dif_w;
  logic       arith;
  logic       sub_like;

  always_comb begin
    sum_w    = {1'b0, a} + {1'b0, b};
    dif_w    = {1'b0, a} - {1'b0, b};
    arith    = 1'b0;
    sub_like = 1'b0;
    known    = 1'b1;
    wr_en    = 1'b1;
    result   = '0;
    unique case (op)
      OPC_MOV: result = b;
      OPC_MVN: result = ~b;
      OPC_ADD: begin result = sum_w[W-1:0]; arith = 1'b1; end
      OPC_SUB: begin result = dif_w[W-1:0]; arith = 1'b1; sub_like = 1'b1; end
      OPC_AND: result = a & b;
      OPC_ORR: result = a | b;
      OPC_EOR: result = a ^ b;
      OPC_BIC: result = a & ~b;
      OPC_CMP: begin
        result = dif_w[W-1:0]; arith = 1'b1; sub_like = 1'b1; wr_en = 1'b0;
      end
      OPC_TST: begin result = a & b; wr_en = 1'b0; end
      OPC_TEQ: begin result = a ^ b; wr_en = 1'b0; end
      default: begin known = 1'b0; wr_en = 1'b0; end
    endcase

    flags_out   = flags_in;
    flags_out.n = result[W-1];
    flags_out.z = (result == '0);
    if (arith) begin
      if (sub_like) begin
        flags_out.c = ~dif_w[W];
        flags_out.v = (a[W-1] != b[W-1]) && (result[W-1] != a[W-1]);
      end else begin
        flags_out.c = sum_w[W];
        flags_out.v = (a[W-1] == b[W-1]) && (result[W-1] != a[W-1]);
      end
    end else begin
      flags_out.c = sh_c;
    end
    if (!known) flags_out = flags_in;
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu import alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0]           in_op,
  input  logic                 in_set_flags,
  input  logic                 in_b_imm,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b_reg,
  input  logic [W-1:0]         in_imm,
  input  logic [1:0]           in_sh_type,
  input  logic [$clog2(W)-1:0] in_sh_amt,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_result,
  output logic                 out_wr_en,
  output logic [3:0]           out_flags
);
  logic [W-1:0] b_pre;
  logic [W-1:0] b_sh;
  logic         sh_c;
  logic [W-1:0] alu_res;
  logic         alu_wen;
  logic         alu_known;
  flags_t       flag_q;
  flags_t       flag_nx;
  logic         accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign b_pre    = in_b_imm ? in_imm : in_b_reg;

  operand_shifter #(.W(W)) u_shift (
    .din (b_pre),
    .kind(shift_kind_e'(in_sh_type)),
    .amt (in_sh_amt),
    .cin (flag_q.c),
    .dout(b_sh),
    .cout(sh_c)
  );

  alu_core #(.W(W)) u_core (
    .a        (in_a),
    .b        (b_sh),
    .sh_c     (sh_c),
    .op       (in_op),
    .flags_in (flag_q),
    .result   (alu_res),
    .wr_en    (alu_wen),
    .known    (alu_known),
    .flags_out(flag_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q     <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= alu_res;
        out_wr_en  <= alu_wen;
        if (in_set_flags && alu_known) flag_q <= flag_nx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_flags = flag_q;
endmodule

// File: rtl/shift_alu_checker.sv
module shift_alu_checker #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [3:0]           in_op,
  input logic                 in_set_flags,
  input logic                 in_b_imm,
  input logic [W-1:0]         in_b_reg,
  input logic [$clog2(W)-1:0] in_sh_amt,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [W-1:0]         out_result,
  input logic                 out_wr_en,
  input logic [3:0]           out_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_wr_en) && $stable(out_flags)));

  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 4'd8 || in_op == 4'd9 || in_op == 4'd10)) |=> (out_valid && !out_wr_en));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_set_flags) |=> $stable(out_flags));

  assert_mvn_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd1 && !in_b_imm && in_sh_amt == '0) |=> (out_result == ~$past(in_b_reg)));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op > 4'd10) |=> (!out_wr_en && out_result == '0 && $stable(out_flags)));
endmodule

bind shift_alu shift_alu_checker #(.W(W)) u_chk (.*);

// File: tb/shift_alu_bench.sv
module shift_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_set_flags = 1'b0;
  logic        in_b_imm = 1'b0;
  logic [31:0] in_a = '0, in_b_reg = '0, in_imm = '0;
  logic [1:0]  in_sh_type = '0;
  logic [4:0]  in_sh_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_flags;

  int errors = 0;
  int checks = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [3:0] mflags = 4'h0;

  typedef struct {
    logic [31:0] res;
    logic        wen;
    logic [3:0]  flg;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  shift_alu u_shift_alu (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8, 4'd9, 4'd10: return "R6";
      default: return "R11";
    endcase
  endfunction

  // Reference model written from the requirements.
  function automatic void model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b0, input logic [1:0] st, input logic [4:0] n,
      input bit setf, inout logic [3:0] fl, output logic [31:0] r, output logic wen);
    logic [63:0] t;
    logic [31:0] b;
    logic        sc, cc, vv;
    bit          ar, known;
    int          k;
    k = int'(n);
    if (k == 0) begin b = b0; sc = fl[1]; end
    else begin
      case (st)
        2'd0: begin t = {32'h0, b0} << k; b = t[31:0]; sc = t[32]; end
        2'd1: begin t = {b0, 32'h0} >> k; b = t[63:32]; sc = t[31]; end
        2'd2: begin t = 64'($signed({b0, 32'h0}) >>> k); b = t[63:32]; sc = t[31]; end
        default: begin t = {b0, b0} >> k; b = t[31:0]; sc = b[31]; end
      endcase
    end
    ar = 0; known = 1; wen = 1; cc = sc; vv = fl[0];
    case (op)
      4'd0: r = b;
      4'd1: r = ~b;
      4'd2: begin t = {32'h0, a} + {32'h0, b}; r = t[31:0]; ar = 1; cc = t[32];
              vv = (a[31] == b[31]) && (r[31] != a[31]); end
      4'd3, 4'd8: begin r = a - b; ar = 1; cc = (a >= b);
              vv = (a[31] != b[31]) && (r[31] != a[31]); wen = (op == 4'd3); end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = a & ~b;
      4'd9: begin r = a & b; wen = 0; end
      4'd10: begin r = a ^ b; wen = 0; end
      default: begin r = 0; wen = 0; known = 0; end
    endcase
    if (!ar) vv = fl[0];
    if (setf && known) fl = {r[31], r == 0, cc, vv};
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] breg,
                      input logic [31:0] imm, input bit bimm, input logic [1:0] st,
                      input logic [4:0] n, input bit setf);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1; in_op = op; in_a = a; in_b_reg = breg; in_imm = imm;
    in_b_imm = bimm; in_sh_type = st; in_sh_amt = n; in_set_flags = setf;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        model(op, a, bimm ? imm : breg, st, n, setf, mflags, e.res, e.wen);
        e.flg = mflags;
        e.tag = tag_of(op);
        if (n != 0) e.tag = {e.tag, "/R2"};
        if (bimm) e.tag = {e.tag, "/R1"};
        if (setf) e.tag = {e.tag, (op == 2 || op == 3 || op == 8) ? "/R7" : "/R8"};
        else e.tag = {e.tag, "/R9"};
        sb.push_back(e);
        break;
      end
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // Consumer ready, with random back-pressure.
  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Monitor / scoreboard.
  logic        held = 0;
  logic [31:0] h_res;
  logic        h_wen;
  logic [3:0]  h_flg;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_result == h_res && out_wr_en == h_wen && out_flags == h_flg,
              "R10", "hold", {out_result, 27'h0, out_wr_en, out_flags}, {h_res, 27'h0, h_wen, h_flg});
      end
      if (out_valid && !out_ready) begin
        held = 1; h_res = out_result; h_wen = out_wr_en; h_flg = out_flags;
      end else held = 0;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(0, "R10", "unexpected result", 64'(out_result), 64'h0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_result == e.res && out_wr_en == e.wen && out_flags == e.flg, e.tag,
                "res/wen/flags", {out_result, 27'h0, out_wr_en, out_flags},
                {e.res, 27'h0, e.wen, e.flg});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R12", "out_valid", 64'(out_valid), 0);
    check(out_flags == 0, "R12", "out_flags", 64'(out_flags), 0);
    check(in_ready == 1, "R12", "in_ready", 64'(in_ready), 1);

    // R3: move with LSL#2 multiplies by 4, move-not inverts.
    send(4'd0, 0, 32'd5, 0, 0, 2'd0, 5'd2, 1);
    send(4'd1, 0, 32'h0F0F_00FF, 0, 0, 2'd0, 5'd0, 1);
    // R1: immediate selection.
    send(4'd0, 0, 32'hDEAD_BEEF, 32'h0000_0123, 1, 2'd0, 5'd0, 0);
    // R4/R7: subtract 1 to zero, borrow, overflow on add.
    send(4'd3, 32'd1, 32'd1, 0, 0, 2'd0, 5'd0, 1);
    send(4'd3, 32'd2, 32'd5, 0, 0, 2'd0, 5'd0, 1);
    send(4'd2, 32'h7FFF_FFFF, 32'd1, 0, 0, 2'd0, 5'd0, 1);
    send(4'd2, 32'hFFFF_FFFF, 32'd1, 0, 0, 2'd0, 5'd0, 1);
    // R4: add with r1 shifted left by 1 (times 3).
    send(4'd2, 32'd7, 32'd7, 0, 0, 2'd0, 5'd1, 0);
    // R5: logic ops incl. bit-clear.
    send(4'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, 2'd0, 5'd0, 1);
    send(4'd5, 32'h1200_0000, 32'h0000_0034, 0, 0, 2'd0, 5'd0, 0);
    send(4'd6, 32'hAAAA_AAAA, 32'hFFFF_0000, 0, 0, 2'd0, 5'd0, 1);
    send(4'd7, 32'hFFFF_FFFF, 32'h0000_FF0F, 0, 0, 2'd0, 5'd0, 1);
    // R6: compare equal, test, test-equal.
    send(4'd8, 32'd9, 32'd9, 0, 0, 2'd0, 5'd0, 1);
    send(4'd9, 32'h0000_00F0, 32'h0000_000F, 0, 0, 2'd0, 5'd0, 1);
    send(4'd10, 32'h8000_0001, 32'h0000_0001, 0, 0, 2'd0, 5'd0, 1);
    // R2: each shift kind, carry out, and zero distance using current C.
    send(4'd8, 32'd5, 32'd3, 0, 0, 2'd0, 5'd0, 1);
    send(4'd0, 0, 32'h1234_5678, 0, 0, 2'd3, 5'd0, 1);
    send(4'd0, 0, 32'h8000_0001, 0, 0, 2'd0, 5'd1, 1);
    send(4'd0, 0, 32'h8000_0003, 0, 0, 2'd1, 5'd1, 1);
    send(4'd0, 0, 32'h8000_0010, 0, 0, 2'd2, 5'd4, 1);
    send(4'd0, 0, 32'h0000_00F1, 0, 0, 2'd3, 5'd4, 1);
    send(4'd0, 0, 32'hFFFF_FFFF, 0, 0, 2'd1, 5'd31, 1);
    send(4'd8, 32'd3, 32'd5, 0, 0, 2'd0, 5'd0, 1);
    send(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 2'd0, 5'd0, 1);
    // R11: reserved opcodes.
    send(4'd11, 32'd1, 32'd2, 0, 0, 2'd0, 5'd0, 1);
    send(4'd15, 32'd1, 32'd2, 0, 0, 2'd0, 5'd0, 1);
    // R9: no flag update without set bit.
    send(4'd3, 32'd0, 32'd1, 0, 0, 2'd0, 5'd0, 0);

    // Random traffic with back-pressure (R10 and all functions).
    bp_on = 1'b1;
    for (int i = 0; i < 600; i++) begin
      send(4'($urandom_range(0, 15)), $urandom, $urandom, $urandom, 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom),
           1'($urandom_range(0, 1)));
    end
    bp_on = 1'b0;
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R10", "drain", 64'(sb.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule